// File: doc/BRIEF.md
# Hamming 7-4 Encoder and Single-Error Corrector

This block holds both halves of a single-error-correcting code that protects a 4-bit data nibble with three even-parity check bits. The encoder half turns a nibble into a 7-bit codeword. The decoder half takes a 7-bit word that may have been corrupted. It recomputes the three checks, reads the result as the position of a flipped bit, inverts that bit, and returns the repaired nibble together with the syndrome and an error flag.

Each half is a stream with its own valid/ready pair on the way in and on the way out, and one register stage sits between them. A word is accepted on a clock edge where in_valid and in_ready are both high. Its result is presented with out_valid high from the following cycle. Back-pressure works as follows. in_ready is high exactly when the output register is empty or is being drained in the same cycle (out_ready high). While out_valid is high and out_ready is low, the output payload holds still and nothing new is taken in. The two halves are independent and may be used at the same time.

Codeword bit numbering: position p (1 to 7) travels on bit p-1 of the 7-bit bus. Check bits sit at positions 1, 2 and 4. The data bits go to the remaining positions, lowest data bit to the lowest free position.

Top module: `hamming74_codec`

## Requirements
- R1: The codeword carries data bit 0 at position 3, bit 1 at position 5, bit 2 at position 6 and bit 3 at position 7, with position p on bus bit p-1.
- R2: Position 1 is set so that positions 1,3,5,7 hold an even number of ones. Position 2 makes 2,3,6,7 even, and position 4 makes 4,5,6,7 even. Every encoder output therefore has a zero syndrome.
- R3: The decoder syndrome is the 3-bit value {c4,c2,c1}. Each cN is the parity recomputed over the group of check bit N. For a single flipped bit it equals that bit's position.
- R4: When the syndrome names a data position (3, 5, 6 or 7), the output nibble has that bit inverted, which restores the transmitted data.
- R5: A syndrome of zero leaves the error flag low and passes the data bits of the received word through unchanged.
- R6: A syndrome of 1, 2 or 4 raises the error flag and leaves the output nibble equal to the received data bits.
- R7: The error flag is high exactly when the syndrome is non-zero.
- R8: Each half presents its result with out_valid high in the cycle after the accepting edge.
- R9: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready low, out_valid stays high and the payload stays stable on the next cycle.
- R10: A synchronous active-high reset clears both out_valid signals, so both in_ready signals read high after reset.
- R11: Nibble 1010 (bit 3 first) encodes to 7'h52, so checks at positions 1,2,4 are 0,1,0. That word with position 4 flipped (7'h5A) decodes to syndrome 4, error high, data 1010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Encoder input word present |
| enc_in_ready | output | 1 | Encoder can accept a word |
| enc_in_data | input | 4 | Data nibble to encode |
| enc_out_valid | output | 1 | Encoder codeword present |
| enc_out_ready | input | 1 | Consumer takes the codeword |
| enc_out_code | output | 7 | Codeword, position p on bit p-1 |
| dec_in_valid | input | 1 | Decoder input word present |
| dec_in_ready | output | 1 | Decoder can accept a word |
| dec_in_code | input | 7 | Received word, position p on bit p-1 |
| dec_out_valid | output | 1 | Decoder result present |
| dec_out_ready | input | 1 | Consumer takes the result |
| dec_out_data | output | 4 | Corrected data nibble |
| dec_out_syndrome | output | 3 | Syndrome {c4,c2,c1} |
| dec_out_error | output | 1 | Non-zero syndrome seen |

## Verification
On every cycle the assertions check several properties. Each encoder codeword must have zero syndrome. A clean received word must pass through. A repaired result must re-encode to within one bit of the received word. Stalled outputs must hold, each accepted word must appear one cycle later, and both outputs must be empty after reset. Only the bench scenarios can show the exact syndrome value for each of the seven flip positions, which bit is inverted, and the fixed test vector. They also show that the flow under random back-pressure matches a behavioural model cycle for cycle.

// File: rtl/hamming74_pkg.sv
package hamming74_pkg;

  localparam int DATA_W = 4;

  function automatic int chk_count(input int d);
    int r;
    r = 0;
    while ((1 << r) < d + r + 1) r++;
    return r;
  endfunction

  localparam int CHK_W  = chk_count(DATA_W);
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int DEC_W  = DATA_W + CHK_W + 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CHK_W-1:0]  syn_t;

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // positions whose index has bit k set
  function automatic code_t cover_mask(input int k);
    code_t m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++)
      if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
    return m;
  endfunction

  function automatic code_t place_data(input data_t d);
    code_t c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= CODE_W; p++)
      if (!is_pow2(p)) begin
        c[p-1] = d[j];
        j++;
      end
    return c;
  endfunction

  function automatic data_t pick_data(input code_t c);
    data_t d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p <= CODE_W; p++)
      if (!is_pow2(p)) begin
        d[j] = c[p-1];
        j++;
      end
    return d;
  endfunction

  function automatic syn_t syndrome_of(input code_t c);
    syn_t s;
    for (int k = 0; k < CHK_W; k++) s[k] = ^(c & cover_mask(k));
    return s;
  endfunction

  function automatic code_t encode_word(input data_t d);
    code_t c;
    c = place_data(d);
    for (int k = 0; k < CHK_W; k++) c[(1 << k) - 1] = ^(c & cover_mask(k));
    return c;
  endfunction

endpackage

// File: rtl/ham_pipe_reg.sv
module ham_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) out_payload <= in_payload;
  end

endmodule

// File: rtl/ham_enc_core.sv
module ham_enc_core
  import hamming74_pkg::*;
(
  input  data_t data,
  output code_t code
);

  code_t placed;
  code_t chk_spread;

  assign placed = place_data(data);

  for (genvar p = 0; p < CODE_W; p++) begin : g_pos
    if (is_pow2(p + 1)) begin : g_chk
      assign chk_spread[p] = ^(placed & cover_mask($clog2(p + 1)));
    end else begin : g_dat
      assign chk_spread[p] = 1'b0;
    end
  end

  assign code = placed | chk_spread;

endmodule

// File: rtl/ham_dec_core.sv
module ham_dec_core
  import hamming74_pkg::*;
(
  input  code_t code,
  output data_t data,
  output syn_t  syndrome,
  output logic  error
);

  code_t flip;
  code_t fixed;

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    assign syndrome[k] = ^(code & cover_mask(k));
  end

  for (genvar p = 0; p < CODE_W; p++) begin : g_flip
    assign flip[p] = (syndrome == syn_t'(p + 1));
  end

  assign fixed = code ^ flip;
  assign data  = pick_data(fixed);
  assign error = |syndrome;

endmodule

// File: rtl/hamming74_codec.sv
module hamming74_codec (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               enc_in_valid,
  output logic                               enc_in_ready,
  input  logic [hamming74_pkg::DATA_W-1:0]   enc_in_data,
  output logic                               enc_out_valid,
  input  logic                               enc_out_ready,
  output logic [hamming74_pkg::CODE_W-1:0]   enc_out_code,
  input  logic                               dec_in_valid,
  output logic                               dec_in_ready,
  input  logic [hamming74_pkg::CODE_W-1:0]   dec_in_code,
  output logic                               dec_out_valid,
  input  logic                               dec_out_ready,
  output logic [hamming74_pkg::DATA_W-1:0]   dec_out_data,
  output logic [hamming74_pkg::CHK_W-1:0]    dec_out_syndrome,
  output logic                               dec_out_error
);
  import hamming74_pkg::*;

  code_t enc_code_c;
  data_t dec_data_c;
  syn_t  dec_syn_c;
  logic  dec_err_c;
  logic [DEC_W-1:0] dec_bundle_in;
  logic [DEC_W-1:0] dec_bundle_out;

  ham_enc_core u_enc (
    .data (enc_in_data),
    .code (enc_code_c)
  );

  ham_pipe_reg #(.W(CODE_W)) u_enc_reg (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (enc_in_valid),
    .in_ready   (enc_in_ready),
    .in_payload (enc_code_c),
    .out_valid  (enc_out_valid),
    .out_ready  (enc_out_ready),
    .out_payload(enc_out_code)
  );

  ham_dec_core u_dec (
    .code     (dec_in_code),
    .data     (dec_data_c),
    .syndrome (dec_syn_c),
    .error    (dec_err_c)
  );

  assign dec_bundle_in = {dec_err_c, dec_syn_c, dec_data_c};

  ham_pipe_reg #(.W(DEC_W)) u_dec_reg (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (dec_in_valid),
    .in_ready   (dec_in_ready),
    .in_payload (dec_bundle_in),
    .out_valid  (dec_out_valid),
    .out_ready  (dec_out_ready),
    .out_payload(dec_bundle_out)
  );

  assign dec_out_data     = dec_bundle_out[DATA_W-1:0];
  assign dec_out_syndrome = dec_bundle_out[DATA_W+CHK_W-1:DATA_W];
  assign dec_out_error    = dec_bundle_out[DEC_W-1];

endmodule

// File: rtl/ham_codec_checker.sv
module ham_codec_checker
  import hamming74_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  enc_in_valid,
  input logic  enc_in_ready,
  input logic  enc_out_valid,
  input logic  enc_out_ready,
  input code_t enc_out_code,
  input logic  dec_in_valid,
  input logic  dec_in_ready,
  input code_t dec_in_code,
  input logic  dec_out_valid,
  input logic  dec_out_ready,
  input data_t dec_out_data,
  input syn_t  dec_out_syndrome,
  input logic  dec_out_error
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R10: both outputs empty right after reset
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!enc_out_valid && !dec_out_valid));

  // R9: stalled encoder output holds
  a_r9_enc_hold: assert property (@(posedge clk) disable iff (rst)
    (enc_out_valid && !enc_out_ready) |=> (enc_out_valid && $stable(enc_out_code)));

  // R9: stalled decoder output holds
  a_r9_dec_hold: assert property (@(posedge clk) disable iff (rst)
    (dec_out_valid && !dec_out_ready) |=>
      (dec_out_valid && $stable(dec_out_data) && $stable(dec_out_syndrome)
       && $stable(dec_out_error)));

  // R2: every codeword leaving the encoder checks clean
  a_r2_enc_zero_syndrome: assert property (@(posedge clk) disable iff (rst)
    enc_out_valid |-> (syndrome_of(enc_out_code) == '0));

  // R8: accepted words appear one cycle later
  a_r8_enc_latency: assert property (@(posedge clk) disable iff (rst)
    (enc_in_valid && enc_in_ready) |=> enc_out_valid);

  a_r8_dec_latency: assert property (@(posedge clk) disable iff (rst)
    (dec_in_valid && dec_in_ready) |=> dec_out_valid);

  // R5: clean words pass through without a flag
  a_r5_dec_clean_pass: assert property (@(posedge clk) disable iff (rst)
    (dec_in_valid && dec_in_ready && (syndrome_of(dec_in_code) == '0)) |=>
      (!dec_out_error && (dec_out_data == pick_data($past(dec_in_code)))));

  // R4: repaired nibble re-encodes within one bit of the received word
  a_r4_dec_nearest: assert property (@(posedge clk) disable iff (rst)
    (dec_in_valid && dec_in_ready) |=>
      ($countones(encode_word(dec_out_data) ^ $past(dec_in_code)) <= 1));

endmodule

bind hamming74_codec ham_codec_checker u_chk (
  .clk             (clk),
  .rst             (rst),
  .enc_in_valid    (enc_in_valid),
  .enc_in_ready    (enc_in_ready),
  .enc_out_valid   (enc_out_valid),
  .enc_out_ready   (enc_out_ready),
  .enc_out_code    (enc_out_code),
  .dec_in_valid    (dec_in_valid),
  .dec_in_ready    (dec_in_ready),
  .dec_in_code     (dec_in_code),
  .dec_out_valid   (dec_out_valid),
  .dec_out_ready   (dec_out_ready),
  .dec_out_data    (dec_out_data),
  .dec_out_syndrome(dec_out_syndrome),
  .dec_out_error   (dec_out_error)
);

// File: tb/sim_hamming74_codec.sv
`timescale 1ns/1ps
module sim_hamming74_codec;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       enc_in_valid = 1'b0;
  logic       enc_in_ready;
  logic [3:0] enc_in_data = '0;
  logic       enc_out_valid;
  logic       enc_out_ready = 1'b1;
  logic [6:0] enc_out_code;
  logic       dec_in_valid = 1'b0;
  logic       dec_in_ready;
  logic [6:0] dec_in_code = '0;
  logic       dec_out_valid;
  logic       dec_out_ready = 1'b1;
  logic [3:0] dec_out_data;
  logic [2:0] dec_out_syndrome;
  logic       dec_out_error;

  int n_checks = 0;
  int n_errors = 0;
  bit cmp_en = 0;
  bit bp_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  hamming74_codec u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_encode(input logic [3:0] d);
    logic [7:1] b;
    b[3] = d[0]; b[5] = d[1]; b[6] = d[2]; b[7] = d[3];
    b[1] = b[3] ^ b[5] ^ b[7];
    b[2] = b[3] ^ b[6] ^ b[7];
    b[4] = b[5] ^ b[6] ^ b[7];
    return b;
  endfunction

  task automatic ref_decode(input logic [6:0] c, output logic [3:0] d,
                            output logic [2:0] s, output logic e);
    logic [7:1] b;
    int acc;
    b = c;
    acc = 0;
    for (int p = 1; p <= 7; p++) if (b[p]) acc = acc ^ p;
    if (acc != 0) b[acc] = ~b[acc];
    d = {b[7], b[6], b[5], b[3]};
    s = acc[2:0];
    e = (acc != 0);
  endtask

  // behavioural model of both output registers
  bit         m_ev = 0;
  logic [6:0] m_ecode;
  bit         m_dv = 0;
  logic [3:0] m_ddata;
  logic [2:0] m_dsyn;
  logic       m_derr;

  always @(posedge clk) begin
    logic [3:0] d; logic [2:0] s; logic e;
    if (rst) begin
      m_ev = 0; m_dv = 0;
    end else begin
      if (!m_ev || enc_out_ready) begin
        m_ev = enc_in_valid;
        if (enc_in_valid) m_ecode = ref_encode(enc_in_data);
      end
      if (!m_dv || dec_out_ready) begin
        m_dv = dec_in_valid;
        if (dec_in_valid) begin
          ref_decode(dec_in_code, d, s, e);
          m_ddata = d; m_dsyn = s; m_derr = e;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(enc_out_valid == m_ev, "R8", "enc_out_valid", enc_out_valid, m_ev);
      chk(enc_in_ready == (!m_ev || enc_out_ready), "R9", "enc_in_ready",
          enc_in_ready, (!m_ev || enc_out_ready));
      chk(dec_out_valid == m_dv, "R8", "dec_out_valid", dec_out_valid, m_dv);
      chk(dec_in_ready == (!m_dv || dec_out_ready), "R9", "dec_in_ready",
          dec_in_ready, (!m_dv || dec_out_ready));
      if (m_ev)
        chk(enc_out_code === m_ecode, "R2", "enc_out_code", enc_out_code, m_ecode);
      if (m_dv) begin
        chk(dec_out_syndrome === m_dsyn, "R3", "dec_out_syndrome",
            dec_out_syndrome, m_dsyn);
        chk(dec_out_data === m_ddata, "R4", "dec_out_data", dec_out_data, m_ddata);
        chk(dec_out_error === m_derr, "R7", "dec_out_error", dec_out_error, m_derr);
      end
    end
  end

  // ready driver for back-pressure phases
  always @(negedge clk) begin
    #0.4;
    if (bp_mode) begin
      enc_out_ready = lfsr[0];
      dec_out_ready = lfsr[3] | lfsr[5];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end else begin
      enc_out_ready = 1'b1;
      dec_out_ready = 1'b1;
    end
  end

  // entered at negedge+0.4, returns at the accepting posedge
  task automatic enc_send(input logic [3:0] d);
    enc_in_valid = 1'b1;
    enc_in_data  = d;
    #0.4;
    while (!enc_in_ready) begin
      @(negedge clk); #0.8;
    end
    @(posedge clk);
  endtask

  task automatic dec_send(input logic [6:0] c);
    dec_in_valid = 1'b1;
    dec_in_code  = c;
    #0.4;
    while (!dec_in_ready) begin
      @(negedge clk); #0.8;
    end
    @(posedge clk);
  endtask

  task automatic dec_directed(input logic [6:0] c, input logic [2:0] es,
                              input logic ee, input logic [3:0] ed, input string req);
    @(negedge clk); #0.4;
    dec_send(c);
    @(negedge clk);
    chk(dec_out_valid == 1'b1, "R8", "dec valid after accept", dec_out_valid, 1);
    chk(dec_out_syndrome == es, req, "syndrome", dec_out_syndrome, es);
    chk(dec_out_error == ee, req, "error flag", dec_out_error, ee);
    chk(dec_out_data == ed, req, "data", dec_out_data, ed);
    #0.4; dec_in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #0.4;
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(enc_out_valid == 1'b0, "R10", "enc_out_valid after reset", enc_out_valid, 0);
    chk(dec_out_valid == 1'b0, "R10", "dec_out_valid after reset", dec_out_valid, 0);
    chk(enc_in_ready == 1'b1, "R10", "enc_in_ready after reset", enc_in_ready, 1);
    chk(dec_in_ready == 1'b1, "R10", "dec_in_ready after reset", dec_in_ready, 1);
    cmp_en = 1;

    // R11 and R1: fixed vector
    #0.4;
    enc_send(4'b1010);
    @(negedge clk);
    chk(enc_out_valid == 1'b1, "R8", "enc valid after accept", enc_out_valid, 1);
    chk(enc_out_code == 7'h52, "R11", "code for 1010", enc_out_code, 7'h52);
    chk({enc_out_code[6], enc_out_code[5], enc_out_code[4], enc_out_code[2]} == 4'b1010,
        "R1", "data positions 7,6,5,3", {enc_out_code[6], enc_out_code[5],
        enc_out_code[4], enc_out_code[2]}, 4'b1010);
    chk({enc_out_code[3], enc_out_code[1], enc_out_code[0]} == 3'b010,
        "R11", "checks at 4,2,1", {enc_out_code[3], enc_out_code[1], enc_out_code[0]}, 3'b010);
    #0.4; enc_in_valid = 1'b0;

    dec_directed(7'h5A, 3'd4, 1'b1, 4'hA, "R11");   // position 4 flipped
    dec_directed(7'h53, 3'd1, 1'b1, 4'hA, "R6");    // position 1 flipped
    dec_directed(7'h50, 3'd2, 1'b1, 4'hA, "R6");    // position 2 flipped
    dec_directed(7'h52, 3'd0, 1'b0, 4'hA, "R5");    // clean
    dec_directed(7'h42, 3'd5, 1'b1, 4'hA, "R4");    // position 5 flipped
    dec_directed(7'h12, 3'd7, 1'b1, 4'hA, "R4");    // position 7 flipped

    // exhaustive streams under back-pressure, checked by the model
    bp_mode = 1;
    @(negedge clk); #0.4;
    fork
      begin
        for (int r = 0; r < 3; r++)
          for (int d = 0; d < 16; d++) begin
            if (((d + r) % 3) == 0) begin
              enc_in_valid = 1'b0;
              @(negedge clk); #0.4;
            end
            enc_send(d[3:0]);
            @(negedge clk); #0.4;
          end
        enc_in_valid = 1'b0;
      end
      begin
        for (int d = 0; d < 16; d++)
          for (int f = 0; f <= 7; f++) begin
            logic [6:0] c;
            c = ref_encode(d[3:0]);
            if (f != 0) c[f-1] = ~c[f-1];
            if (((d + f) % 5) == 0) begin
              dec_in_valid = 1'b0;
              @(negedge clk); #0.4;
            end
            dec_send(c);
            @(negedge clk); #0.4;
          end
        dec_in_valid = 1'b0;
      end
    join

    // mid-stream reset with outputs possibly pending
    bp_mode = 0;
    enc_in_valid = 1'b1; dec_in_valid = 1'b1;
    @(negedge clk); #0.4;
    rst = 1'b1;
    enc_in_valid = 1'b0; dec_in_valid = 1'b0;
    @(negedge clk); #0.4;
    rst = 1'b0;
    @(negedge clk);
    chk(enc_out_valid == 1'b0, "R10", "enc_out_valid after mid reset", enc_out_valid, 0);
    chk(dec_out_valid == 1'b0, "R10", "dec_out_valid after mid reset", dec_out_valid, 0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule